// File: doc/BRIEF.md
# Arbitrating Two-Wire Bus Master Packet Sender

This block sends one transaction on a shared two-wire serial bus. More than one master may use the bus. A transaction is a START condition, an address byte whose lowest bit is the read/write flag, one or more data bytes, and a STOP condition. The block drives the data line only through an open-drain pull-low output. It reads the line back through a two-stage synchronizer.

A separate clock synchronizer supplies two single-cycle strobes. One strobe falls in the middle of each clock-low phase and the other in the middle of each clock-high phase. The block changes the data line only on a low strobe, except when it forms START and STOP. It compares the line with what it drove on every high strobe.

A released-high bit that reads back low means another master has won. When that happens, the block lets go of the data line at once, raises a sticky flag, and keeps asking for clock pulses until the current nine-bit packet ends. If the loss came during the address packet, it then reports whether the winning master was addressing this block's own address. Commands arrive one byte at a time through a valid/ready handshake.

Top module: `mm_bus_sender`

## Requirements
- R1: After reset the data line is released (`sda_drive_low`=0), `cmd_ready`=1, `bus_clk_en`=0, and `arb_lost`, `addr_match` and `cmd_reject` are 0.
- R2: An accepted START command (`cmd_op`=2'b01, byte = address in bits 7..1, R/W in bit 0) leaves the line released until the next high strobe. On that strobe the block pulls the line low, so the line falls while the clock is high.
- R3: Each packet takes nine clock periods. Bits 7 down to 0 of the byte are placed on the line one per low strobe: a 0 pulls low and a 1 releases. In the ninth period the line is released for the receiver.
- R4: A DATA (2'b10), STOP (2'b11) or reserved (2'b00) command while no transaction is open is refused. `cmd_reject` pulses for one cycle and the line stays released. This refuses a STOP with no address before it. A START while a transaction is open is refused the same way.
- R5: When a bit the block released reads back low on a high strobe, `arb_lost` is set and the line is released on that same clock edge.
- R6: A bit that the block drove low never sets `arb_lost`.
- R7: After a loss, the block never pulls the line low. It keeps `bus_clk_en` high until the ninth period of the packet ends, then returns to idle, where a DATA command is refused.
- R8: If the loss happened in the address packet, `addr_match` is set at the end of that packet when bits 7..1 read from the line equal `own_addr`. A loss in a data packet leaves `addr_match` at 0.
- R9: The comparison is active on every bit of every data packet, so a loss inside a data packet is also detected.
- R10: After each packet the block won, `ack_bit` holds the line value sampled in the ninth period: 0 means acknowledged, 1 means not acknowledged.
- R11: A STOP command (2'b11) after a packet pulls the line low on the next low strobe and releases it on the following high strobe. The line therefore rises while the clock is high, and the block returns to idle.
- R12: `arb_lost` and `addr_match` stay set until the next command handshake, which clears them.
- R13: `sda_drive_low` changes only on the clock edge where a low or high strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sda_in | input | 1 | Raw data line level as seen at the pad |
| sda_drive_low | output | 1 | Open-drain control: 1 pulls the data line low |
| scl_low_tick | input | 1 | One-cycle strobe in the middle of each clock-low phase |
| scl_high_tick | input | 1 | One-cycle strobe in the middle of each clock-high phase |
| bus_clk_en | output | 1 | Requests clock pulses from the synchronizer |
| own_addr | input | 7 | This block's own bus address |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 01 START+address, 10 DATA, 11 STOP, 00 reserved |
| cmd_byte | input | 8 | Address byte or data byte |
| cmd_ready | output | 1 | Block can take a command (idle or between packets) |
| cmd_reject | output | 1 | One-cycle pulse: the last command was refused |
| pkt_done | output | 1 | One-cycle pulse at the end of each nine-bit packet |
| ack_bit | output | 1 | Acknowledge seen after the last won packet (0 = ACK) |
| arb_lost | output | 1 | Sticky: arbitration was lost |
| addr_match | output | 1 | Sticky: winner addressed `own_addr` |

## Verification
Transactions are sent first with a silent competitor and then against a modelled second master whose bytes are combined with this block's bytes as a wired AND. The competitor's address is set equal to this block's target, so arbitration reaches the data bytes. It is also set to `own_addr`, which separates a loss that should report a match from one that should not. It is also set to a lower or higher address than the target. The lower address separates a loss during the address from a win where this block drove low, and the higher one tells those two outcomes apart the other way. Random addresses, data, lengths and acknowledge values add more patterns. Directed commands in the wrong state show that refusal, STOP timing and the sticky flags behave as the requirements state.

// File: rtl/mm_bus_pkg.sv
// Shared encodings for the arbitrating bus sender.
// Assumes: the command codes below are the ones software and the bench use.
package mm_bus_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_START = 2'b01,
        OP_DATA  = 2'b10,
        OP_STOP  = 2'b11
    } cmd_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_BITS,
        S_HOLD,
        S_STOP_LOW,
        S_STOP_HIGH
    } mst_state_e;
endpackage

// File: rtl/mm_line_sync.sv
// Multi-stage synchronizer for the raw data line level.
// Assumes: the line idles high, so the stages reset to 1.
module mm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_raw,
    output logic d_sync
);
    logic [STAGES-1:0] sr;

    // Shift the raw level through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d_raw};
    end

    assign d_sync = sr[STAGES-1];
endmodule

// File: rtl/mm_pkt_shifter.sv
// Per-packet bit engine: transmit shift register, received-address shift
// register and bit counter covering the data bits and the acknowledge slot.
// Assumes: load and step are never asserted together.
module mm_pkt_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              step,
    input  logic              in_bit,
    output logic              tx_bit,
    output logic [DATA_W-2:0] rx_addr,
    output logic              data_slot,
    output logic              last_data,
    output logic              ack_slot
);
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-2:0] rx_sr;
    logic [CNT_W-1:0]  idx;

    // Load a new byte, or advance one bit on each clock-high strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            idx   <= '0;
        end else if (load) begin
            tx_sr <= load_byte;
            rx_sr <= '0;
            idx   <= '0;
        end else if (step) begin
            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            if (idx < ACK_IDX) rx_sr <= {rx_sr[DATA_W-3:0], in_bit};
            idx <= idx + 1'b1;
        end
    end

    assign tx_bit    = tx_sr[DATA_W-1];
    assign rx_addr   = rx_sr;
    assign data_slot = (idx < ACK_IDX);
    assign last_data = (idx == LAST_IDX);
    assign ack_slot  = (idx == ACK_IDX);
endmodule

// File: rtl/mm_bus_sender.sv
// Arbitrating master packet sender for a two-wire open-drain bus.
// Sends START, address byte, data bytes and STOP under byte commands, checks
// every sent bit against the line, and after a loss finishes the packet
// released and checks whether the winner addressed own_addr.
// Assumes: scl_low_tick/scl_high_tick come from an external clock
// synchronizer, one cycle wide, several cycles apart, alternating.
module mm_bus_sender
    import mm_bus_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_in,
    output logic              sda_drive_low,
    input  logic              scl_low_tick,
    input  logic              scl_high_tick,
    output logic              bus_clk_en,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_ready,
    output logic              cmd_reject,
    output logic              pkt_done,
    output logic              ack_bit,
    output logic              arb_lost,
    output logic              addr_match
);
    localparam int ADDR_W = DATA_W - 1;

    mst_state_e        state;
    cmd_op_e           op;
    logic              sda_s;
    logic              accept;
    logic              load;
    logic              step;
    logic              tx_bit;
    logic [ADDR_W-1:0] rx_addr;
    logic              data_slot;
    logic              last_data;
    logic              ack_slot;
    logic              listening;
    logic              is_addr;
    logic              lose_now;

    mm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_raw  (sda_in),
        .d_sync (sda_s)
    );

    mm_pkt_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_byte (cmd_byte),
        .step      (step),
        .in_bit    (sda_s),
        .tx_bit    (tx_bit),
        .rx_addr   (rx_addr),
        .data_slot (data_slot),
        .last_data (last_data),
        .ack_slot  (ack_slot)
    );

    // Handshake, shifter control and bit-level loss detection.
    always_comb begin
        op         = cmd_op_e'(cmd_op);
        cmd_ready  = (state == S_IDLE) || (state == S_HOLD);
        accept     = cmd_valid && cmd_ready;
        load       = accept && (((state == S_IDLE) && (op == OP_START)) ||
                                ((state == S_HOLD) && (op == OP_DATA)));
        step       = (state == S_BITS) && scl_high_tick;
        lose_now   = step && data_slot && !listening && tx_bit && !sda_s;
        bus_clk_en = (state == S_START) || (state == S_BITS) ||
                     (state == S_STOP_LOW) || (state == S_STOP_HIGH);
    end

    // Transaction sequencing, line drive and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= S_IDLE;
            sda_drive_low <= 1'b0;
            listening     <= 1'b0;
            is_addr       <= 1'b0;
            arb_lost      <= 1'b0;
            addr_match    <= 1'b0;
            ack_bit       <= 1'b1;
            cmd_reject    <= 1'b0;
            pkt_done      <= 1'b0;
        end else begin
            cmd_reject <= 1'b0;
            pkt_done   <= 1'b0;
            if (accept) begin
                arb_lost   <= 1'b0;
                addr_match <= 1'b0;
            end
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        if (op == OP_START) begin
                            state   <= S_START;
                            is_addr <= 1'b1;
                        end else begin
                            cmd_reject <= 1'b1;
                        end
                    end
                end
                S_START: begin
                    if (scl_high_tick) begin
                        sda_drive_low <= 1'b1;
                        state         <= S_BITS;
                    end
                end
                S_BITS: begin
                    if (scl_low_tick) begin
                        sda_drive_low <= data_slot && !listening && !tx_bit;
                    end else if (scl_high_tick) begin
                        if (lose_now) begin
                            arb_lost      <= 1'b1;
                            listening     <= 1'b1;
                            sda_drive_low <= 1'b0;
                        end
                        if (last_data && is_addr && (listening || lose_now))
                            addr_match <= (rx_addr == own_addr);
                        if (ack_slot) begin
                            pkt_done  <= 1'b1;
                            is_addr   <= 1'b0;
                            if (listening) begin
                                listening <= 1'b0;
                                state     <= S_IDLE;
                            end else begin
                                ack_bit <= sda_s;
                                state   <= S_HOLD;
                            end
                        end
                    end
                end
                S_HOLD: begin
                    if (accept) begin
                        if (op == OP_DATA)      state <= S_BITS;
                        else if (op == OP_STOP) state <= S_STOP_LOW;
                        else                    cmd_reject <= 1'b1;
                    end
                end
                S_STOP_LOW: begin
                    if (scl_low_tick) begin
                        sda_drive_low <= 1'b1;
                        state         <= S_STOP_HIGH;
                    end
                end
                S_STOP_HIGH: begin
                    if (scl_high_tick) begin
                        sda_drive_low <= 1'b0;
                        state         <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R4: a non-START command while idle is refused and opens nothing.
    a_r4_idle_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && state == S_IDLE && op != OP_START)
        |=> (cmd_reject && state == S_IDLE && !sda_drive_low));

    // R5: the flag rises only with the line already released.
    a_r5_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> !sda_drive_low);

    // R6: a bit driven low cannot lose arbitration.
    a_r6_low_never_loses: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> $past(!sda_drive_low));

    // R7: while finishing a lost packet the line is never pulled and clocks continue.
    a_r7_listen_released: assert property (@(posedge clk) disable iff (!rst_n)
        listening |-> (!sda_drive_low && bus_clk_en));

    // R11: the release at the end of STOP happens on a high strobe and ends the transaction.
    a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_drive_low) && $past(state) == S_STOP_HIGH)
        |-> ($past(scl_high_tick) && state == S_IDLE));

    // R12: a new START handshake clears both sticky flags.
    a_r12_clear_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state == S_IDLE && op == OP_START) |=> (!arb_lost && !addr_match));

    // R13: the line drive changes only on an edge carrying a strobe.
    a_r13_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low))
        |-> ($past(scl_low_tick) || $past(scl_high_tick)));
endmodule

// File: tb/mm_bus_sender_test.sv
// Self-checking bench: wired-AND bus model with a second master and a slave.
module mm_bus_sender_test;
    localparam logic [6:0] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_low_tick = 1'b0, scl_high_tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_byte = 8'h00;
    logic       comp_drv = 1'b1, slave_drv = 1'b1;
    logic       sda_in, sda_drive_low, bus_clk_en, cmd_ready, cmd_reject;
    logic       pkt_done, ack_bit, arb_lost, addr_match;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit our_lost, comp_lost, lost_in_addr;
    logic [7:0] line_byte;

    always #2 clk = ~clk;  // 250 MHz

    assign sda_in = !sda_drive_low & comp_drv & slave_drv;

    mm_bus_sender uut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .sda_drive_low(sda_drive_low),
        .scl_low_tick(scl_low_tick), .scl_high_tick(scl_high_tick),
        .bus_clk_en(bus_clk_en), .own_addr(OWN), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
        .cmd_reject(cmd_reject), .pkt_done(pkt_done), .ack_bit(ack_bit),
        .arb_lost(arb_lost), .addr_match(addr_match)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic low_tick();
        @(negedge clk) scl_low_tick = 1'b1;
        @(negedge clk) scl_low_tick = 1'b0;
    endtask

    task automatic high_tick();
        @(negedge clk) scl_high_tick = 1'b1;
        @(negedge clk) scl_high_tick = 1'b0;
    endtask

    // Expected line drive for each bit follows R3 (and R7 once lost).
    task automatic run_packet(input logic [7:0] ours, input bit comp_on,
                              input logic [7:0] cbyte, input bit sack, input bit is_addr);
        int bad = 0;
        for (int b = 0; b < 9; b++) begin
            logic exp_drv, oe, ce, line;
            low_tick();
            if (b < 8) begin
                comp_drv  = (comp_on && !comp_lost) ? cbyte[7-b] : 1'b1;
                slave_drv = 1'b1;
            end else begin
                comp_drv  = 1'b1;
                slave_drv = sack;
            end
            exp_drv = (b < 8 && !our_lost) ? !ours[7-b] : 1'b0;
            if (sda_drive_low !== exp_drv) bad++;
            repeat (6) @(negedge clk);
            high_tick();
            if (b < 8) begin
                oe = our_lost ? 1'b1 : ours[7-b];
                ce = comp_drv;
                line = oe & ce;
                line_byte[7-b] = line;
                if (!our_lost && oe && !line) begin
                    our_lost = 1;
                    lost_in_addr = is_addr;
                    chk(sda_drive_low == 1'b0 && arb_lost == 1'b1,
                        "R5 release and flag on loss", {sda_drive_low, arb_lost}, 2'b01);
                end
                if (ce && !line) comp_lost = 1;
            end
        end
        chk(bad == 0, our_lost ? "R7 released after loss" : "R3 bit order", bad, 0);
        comp_drv = 1'b1; slave_drv = 1'b1;
    endtask

    task automatic run_txn(input logic [7:0] addr, input int n, input logic [31:0] data,
                           input bit comp_on, input logic [7:0] caddr,
                           input logic [31:0] cdata, input logic [4:0] sacks);
        our_lost = 0; comp_lost = 0; lost_in_addr = 0; line_byte = '0;
        send_cmd(2'b01, addr);
        chk(sda_drive_low == 1'b0 && bus_clk_en, "R2 released before SCL high", sda_drive_low, 0);
        repeat (3) @(negedge clk);
        high_tick();
        chk(sda_drive_low == 1'b1, "R2 START pull low", sda_drive_low, 1);
        run_packet(addr, comp_on, caddr, sacks[0], 1);
        chk(arb_lost == our_lost, "R5 R6 arbitration flag after address", arb_lost, our_lost);
        if (our_lost) begin
            chk(addr_match == (line_byte[7:1] == OWN), "R8 address match", addr_match,
                line_byte[7:1] == OWN);
            chk(!bus_clk_en && cmd_ready, "R7 idle after lost packet", bus_clk_en, 0);
            return;
        end
        chk(ack_bit == sacks[0], "R10 address ack", ack_bit, sacks[0]);
        for (int i = 0; i < n; i++) begin
            send_cmd(2'b10, data[8*i +: 8]);
            run_packet(data[8*i +: 8], comp_on, cdata[8*i +: 8], sacks[i+1], 0);
            chk(arb_lost == our_lost, "R9 data arbitration flag", arb_lost, our_lost);
            if (our_lost) begin
                chk(addr_match == 1'b0, "R8 no match on data loss", addr_match, 0);
                return;
            end
            chk(ack_bit == sacks[i+1], "R10 data ack", ack_bit, sacks[i+1]);
        end
        send_cmd(2'b11, 8'h00);
        low_tick();
        chk(sda_drive_low == 1'b1, "R11 STOP low during SCL low", sda_drive_low, 1);
        repeat (4) @(negedge clk);
        high_tick();
        chk(sda_drive_low == 1'b0 && cmd_ready && !bus_clk_en, "R11 STOP release",
            sda_drive_low, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed = 32'd20240611;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sda_drive_low && cmd_ready && !bus_clk_en && !arb_lost && !addr_match && !cmd_reject,
            "R1 reset state", {sda_drive_low, cmd_ready, bus_clk_en}, 3'b010);

        // R4: refused commands while idle (empty message, stray data, reserved).
        send_cmd(2'b11, 8'h00);
        chk(cmd_reject && !sda_drive_low && cmd_ready, "R4 STOP with no address refused",
            cmd_reject, 1);
        send_cmd(2'b10, 8'h55);
        chk(cmd_reject && !bus_clk_en, "R4 DATA while idle refused", cmd_reject, 1);
        send_cmd(2'b00, 8'h00);
        chk(cmd_reject, "R4 reserved op refused", cmd_reject, 1);

        // Silent competitor, ACK then NACK.
        run_txn(8'hA4, 2, 32'h0000_3CC3, 0, 8'h00, 32'h0, 5'b00100);
        // Competitor lower address: this block loses during the address.
        run_txn(8'hA4, 1, 32'h0000_0011, 1, 8'h24, 32'h0, 5'b00000);
        // Competitor higher address: this block drives low and wins (R6).
        run_txn(8'h24, 1, 32'h0000_0077, 1, 8'hA4, 32'h0, 5'b00000);
        chk(!arb_lost, "R6 driven-low bit never loses", arb_lost, 0);
        // Competitor addresses own_addr and wins: match expected.
        run_txn(8'hFE, 1, 32'h0000_0001, 1, {OWN, 1'b0}, 32'h0, 5'b00000);
        chk(addr_match, "R8 winner addressed own address", addr_match, 1);

        // R12: flags sticky until the next handshake.
        repeat (20) @(negedge clk);
        chk(arb_lost && addr_match, "R12 flags sticky", {arb_lost, addr_match}, 2'b11);
        send_cmd(2'b10, 8'h00);
        chk(cmd_reject && !arb_lost && !addr_match, "R7 R12 idle after loss, flags cleared",
            {cmd_reject, arb_lost, addr_match}, 3'b100);

        // Same address, data differs: loss inside a data packet (R9).
        run_txn(8'h40, 2, 32'h0000_F0FF, 1, 8'h40, 32'h0000_F07F, 5'b00000);
        chk(arb_lost, "R9 loss detected in data packet", arb_lost, 1);

        // R4: START while a transaction is open is refused.
        our_lost = 0; comp_lost = 0;
        send_cmd(2'b01, 8'h10);
        high_tick();
        run_packet(8'h10, 0, 8'h00, 1'b0, 1);
        send_cmd(2'b01, 8'h12);
        chk(cmd_reject && cmd_ready, "R4 START inside transaction refused", cmd_reject, 1);
        send_cmd(2'b11, 8'h00);
        low_tick();
        repeat (4) @(negedge clk);
        high_tick();
        chk(!sda_drive_low && cmd_ready && !bus_clk_en, "R11 STOP after refused START",
            sda_drive_low, 0);

        // Random transactions.
        for (int t = 0; t < 30; t++) begin
            logic [7:0]  a, ca;
            logic [31:0] d, cd;
            int          n, sel;
            bit          con;
            a   = $urandom;
            d   = $urandom;
            n   = 1 + ($urandom % 3);
            con = $urandom % 2;
            sel = $urandom % 3;
            ca  = (sel == 0) ? a : (sel == 1) ? {OWN, a[0]} : 8'($urandom);
            cd  = ($urandom % 2) ? d : 32'($urandom);
            run_txn(a, n, d, con, ca, cd, 5'($urandom));
            repeat (5) @(negedge clk);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule